// File: doc/BRIEF.md
# Calibration Memory Copy Sequencer

This block fills a volatile static calibration store with the contents of a nonvolatile factory calibration store, one word at a time. The copy runs by itself as soon as reset is released, and runs again whenever software pulses a request input while no copy is in progress. When the last word has been written, the block drops its request bit, raises a done bit and reports a factory-calibrated state on a 2-bit status field.

The copy is deliberately slow. A free-running counter on the main converter clock makes a one-cycle step enable, and each step moves one word. A divider setting chooses the step period as a power of two. Setting 0 gives the longest period. Each increment of the setting halves the period, and with it the whole copy time. The same slow enable is meant to pace other calibration work, so the counter is never restarted by a copy. With the default parameters, a 100 MHz clock and setting 0, a full copy takes about 21 ms.

Both memories are outside the block and are plain synchronous arrays. The factory store is read through an enable and an address, and it returns its data exactly one cycle later. The static store is written through an enable, an address and data. Neither port has back-pressure: each memory must accept every access in the cycle it is issued. Control and status pins are plain levels or pulses.

Top module: `calx_seq_top`

## Requirements
- R1: After reset is released, a copy of every factory location into the static store starts without any request. The copy runs to completion, and `xfer_req` reads 1 from reset until that copy ends.
- R2: In the cycle after the last static write of a copy, `xfer_done` is 1, `xfer_req` is 0 and `cal_state` is 2'b10, the factory-calibrated code.
- R3: A one-cycle pulse on `xfer_req_set` while `xfer_req` is 0 starts a new full copy. In the next cycle `xfer_req` is 1, `xfer_done` is 0 and `cal_state` is 2'b00, the uncalibrated code.
- R4: A pulse on `xfer_req_set` while `xfer_req` is 1 has no effect. The running copy is neither restarted nor extended, and it still writes each location exactly once.
- R5: Each step reads factory address a. In the next cycle, static address a is written with the data the factory store returned. Addresses go from 0 up to WORDS-1, each once per copy.
- R6: Within one copy, successive factory reads are exactly 2^(N_MAX - `div_sel`) cycles apart. Any `div_sel` of N_MAX or more gives one read every cycle.
- R7: Let P be the step period. The time from a copy starting (R3) to `xfer_done` rising lies between (WORDS-1)*P+2 and WORDS*P+2 cycles. Setting 0 gives the largest P.
- R8: In reset, and in the first cycle after it, `xfer_done` is 0, `cal_state` is 2'b00 and no static write is issued.
- R9: Once a copy is complete, no factory read or static write is issued until a new copy starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_req_set | input | 1 | One-cycle pulse from software asking for a copy |
| div_sel | input | SEL_W | Step-period setting; period is 2^(N_MAX - div_sel), floored at 1 |
| fmem_rd_en | output | 1 | Factory store read enable |
| fmem_addr | output | ADDR_W | Factory store read address |
| fmem_rd_data | input | DATA_W | Factory store data, valid one cycle after the read |
| smem_wr_en | output | 1 | Static store write enable |
| smem_addr | output | ADDR_W | Static store write address |
| smem_wr_data | output | DATA_W | Static store write data |
| xfer_req | output | 1 | Request bit: 1 while a copy is pending or running |
| xfer_done | output | 1 | Set when a copy completes, cleared when a new copy starts |
| cal_state | output | 2 | 2'b00 uncalibrated, 2'b10 factory calibrated |

## Verification
The bench builds the block with ADDR_W=3, DATA_W=6, N_MAX=4 and SEL_W=3. This gives an eight-word copy whose step period runs from 16 cycles at setting 0 down to 1 cycle. With these values, the full copy at the slowest setting can be checked, along with the back-to-back case and settings at or above N_MAX, which must clamp to a period of 1. Because the store is short, the bench can run several copies with different factory contents. It can also send a request in the middle of a copy and confirm that nothing is written after completion, all within a short run.

// File: rtl/calx_pkg.sv
package calx_pkg;

  // Values reported on the 2-bit calibration-state field
  typedef enum logic [1:0] {
    CAL_NONE    = 2'b00,
    CAL_FACTORY = 2'b10
  } cal_state_e;

endpackage

// File: rtl/calx_clkdiv.sv
// Free-running step-enable generator: one pulse every 2^(N_MAX - sel) clocks
module calx_clkdiv #(
  parameter int N_MAX = 15,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  output logic             step
);

  logic [N_MAX-1:0] cnt_q;
  logic [N_MAX-1:0] low_mask;
  int               span;

  always_comb begin
    if (int'(div_sel) >= N_MAX) span = 0;
    else                        span = N_MAX - int'(div_sel);
    for (int b = 0; b < N_MAX; b++) low_mask[b] = (b < span);
  end

  // step fires when all bits under the mask are ones
  assign step = &(cnt_q | ~low_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/calx_walker.sv
// Address walker: issues factory reads on step, forwards data to static writes
module calx_walker #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              busy,
  input  logic              step,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              last_wr
);

  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] addr_q;
  logic              issued_all_q;
  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;

  assign rd_en   = busy && step && !issued_all_q;
  assign rd_addr = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q       <= '0;
      issued_all_q <= 1'b0;
      pend_q       <= 1'b0;
      pend_addr_q  <= '0;
    end else begin
      if (start) begin
        addr_q       <= '0;
        issued_all_q <= 1'b0;
      end else if (rd_en) begin
        addr_q <= addr_q + 1'b1;
        if (addr_q == LAST) issued_all_q <= 1'b1;
      end
      pend_q      <= rd_en;
      pend_addr_q <= addr_q;
    end
  end

  // one-cycle read latency: data arrives with the pending slot
  assign wr_en   = pend_q;
  assign wr_addr = pend_addr_q;
  assign wr_data = rd_data;
  assign last_wr = pend_q && (pend_addr_q == LAST);

endmodule

// File: rtl/calx_status.sv
// Request / done / calibration-state bookkeeping
module calx_status
  import calx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_set,
  input  logic       last_wr,
  output logic       start,
  output logic       busy,
  output logic       done,
  output logic [1:0] cal_state
);

  logic       req_q;
  logic       done_q;
  cal_state_e cal_q;

  assign start = req_set && !req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b1;   // copy after reset runs without software action
      done_q <= 1'b0;
      cal_q  <= CAL_NONE;
    end else if (last_wr) begin
      req_q  <= 1'b0;
      done_q <= 1'b1;
      cal_q  <= CAL_FACTORY;
    end else if (start) begin
      req_q  <= 1'b1;
      done_q <= 1'b0;
      cal_q  <= CAL_NONE;
    end
  end

  assign busy      = req_q;
  assign done      = done_q;
  assign cal_state = cal_q;

endmodule

// File: rtl/calx_seq_top.sv
module calx_seq_top #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 6,
  parameter int N_MAX  = 15,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_req_set,
  input  logic [SEL_W-1:0]  div_sel,
  output logic              fmem_rd_en,
  output logic [ADDR_W-1:0] fmem_addr,
  input  logic [DATA_W-1:0] fmem_rd_data,
  output logic              smem_wr_en,
  output logic [ADDR_W-1:0] smem_addr,
  output logic [DATA_W-1:0] smem_wr_data,
  output logic              xfer_req,
  output logic              xfer_done,
  output logic [1:0]        cal_state
);

  logic step;
  logic start;
  logic busy;
  logic last_wr;

  calx_clkdiv #(.N_MAX(N_MAX), .SEL_W(SEL_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_sel (div_sel),
    .step    (step)
  );

  calx_walker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .step    (step),
    .rd_en   (fmem_rd_en),
    .rd_addr (fmem_addr),
    .rd_data (fmem_rd_data),
    .wr_en   (smem_wr_en),
    .wr_addr (smem_addr),
    .wr_data (smem_wr_data),
    .last_wr (last_wr)
  );

  calx_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_set   (xfer_req_set),
    .last_wr   (last_wr),
    .start     (start),
    .busy      (busy),
    .done      (xfer_done),
    .cal_state (cal_state)
  );

  assign xfer_req = busy;

endmodule

// File: rtl/calx_seq_checker.sv
module calx_seq_checker #(
  parameter int ADDR_W = 6,
  parameter int N_MAX  = 15,
  parameter int SEL_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  div_sel,
  input logic              fmem_rd_en,
  input logic [ADDR_W-1:0] fmem_addr,
  input logic              smem_wr_en,
  input logic [ADDR_W-1:0] smem_addr,
  input logic              xfer_req,
  input logic              xfer_done,
  input logic [1:0]        cal_state
);

  int   gap_q;
  logic seen_q;
  int   period;

  always_comb begin
    if (int'(div_sel) >= N_MAX) period = 1;
    else                        period = 1 << (N_MAX - int'(div_sel));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else begin
      if (fmem_rd_en) begin
        gap_q  <= 1;
        seen_q <= 1'b1;
      end else begin
        gap_q <= gap_q + 1;
      end
      if (!xfer_req) seen_q <= 1'b0;
    end
  end

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    smem_wr_en |-> ($past(fmem_rd_en) && smem_addr == $past(fmem_addr))); // R5

  AST_DONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_done) |-> (!xfer_req && cal_state == 2'b10)); // R2

  AST_REQ_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> !xfer_done); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_req |-> !fmem_rd_en); // R9

  AST_READ_PACE: assert property (@(posedge clk) disable iff (!rst_n)
    (fmem_rd_en && seen_q) |-> (gap_q == period)); // R6

endmodule

bind calx_seq_top calx_seq_checker #(.ADDR_W(ADDR_W), .N_MAX(N_MAX), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .div_sel    (div_sel),
  .fmem_rd_en (fmem_rd_en),
  .fmem_addr  (fmem_addr),
  .smem_wr_en (smem_wr_en),
  .smem_addr  (smem_addr),
  .xfer_req   (xfer_req),
  .xfer_done  (xfer_done),
  .cal_state  (cal_state)
);

// File: tb/test_calx_seq_top.sv
`timescale 1ns/1ps
module test_calx_seq_top;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 6;
  localparam int N_MAX  = 4;
  localparam int SEL_W  = 3;
  localparam int WORDS  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              xfer_req_set = 1'b0;
  logic [SEL_W-1:0]  div_sel = '0;
  logic              fmem_rd_en;
  logic [ADDR_W-1:0] fmem_addr;
  logic [DATA_W-1:0] fmem_rd_data;
  logic              smem_wr_en;
  logic [ADDR_W-1:0] smem_addr;
  logic [DATA_W-1:0] smem_wr_data;
  logic              xfer_req;
  logic              xfer_done;
  logic [1:0]        cal_state;

  always #2 clk = ~clk;   // 250 MHz

  calx_seq_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_MAX(N_MAX), .SEL_W(SEL_W)) i_calx_seq_top (
    .clk(clk), .rst_n(rst_n), .xfer_req_set(xfer_req_set), .div_sel(div_sel),
    .fmem_rd_en(fmem_rd_en), .fmem_addr(fmem_addr), .fmem_rd_data(fmem_rd_data),
    .smem_wr_en(smem_wr_en), .smem_addr(smem_addr), .smem_wr_data(smem_wr_data),
    .xfer_req(xfer_req), .xfer_done(xfer_done), .cal_state(cal_state)
  );

  // memory models
  logic [DATA_W-1:0] fmem [WORDS];
  logic [DATA_W-1:0] smem [WORDS];
  always_ff @(posedge clk) if (fmem_rd_en) fmem_rd_data <= fmem[fmem_addr];

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard
  logic [ADDR_W+DATA_W-1:0] exp_q[$];
  int  exp_period = 1 << N_MAX;
  int  last_wr_cyc;
  bit  have_prev = 0;
  int  wr_count = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period_of(input int sel);
    return (sel >= N_MAX) ? 1 : (1 << (N_MAX - sel));
  endfunction

  always @(negedge clk) begin
    if (rst_n && smem_wr_en) begin
      wr_count++;
      smem[smem_addr] = smem_wr_data;
      if (exp_q.size() == 0) begin
        check(0, "R9 write with empty scoreboard", int'(smem_addr), -1);
      end else begin
        logic [ADDR_W+DATA_W-1:0] e;
        e = exp_q.pop_front();
        check({smem_addr, smem_wr_data} == e, "R5 write addr/data",
              int'({smem_addr, smem_wr_data}), int'(e));
      end
      if (have_prev)
        check(cyc - last_wr_cyc == exp_period, "R6 step spacing",
              cyc - last_wr_cyc, exp_period);
      have_prev   = 1;
      last_wr_cyc = cyc;
    end
  end

  // driver: load factory content and push expected writes
  task automatic load_and_expect(input int seed);
    for (int i = 0; i < WORDS; i++) begin
      fmem[i] = DATA_W'(i * seed + 7 * (seed % 5) + 1);
      exp_q.push_back({ADDR_W'(i), fmem[i]});
    end
    have_prev = 0;
    wr_count  = 0;
  endtask

  task automatic wait_done(output int waited);
    waited = 0;
    while (!xfer_done && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic finish_checks(input string tag);
    check(xfer_done == 1'b1, "R2 done set", int'(xfer_done), 1);
    check(xfer_req == 1'b0, "R2 request cleared", int'(xfer_req), 0);
    check(cal_state == 2'b10, "R2 factory state", int'(cal_state), 2);
    check(exp_q.size() == 0, "R5 all locations written", exp_q.size(), 0);
    check(wr_count == WORDS, "R4 write count", wr_count, WORDS);
    for (int i = 0; i < WORDS; i++)
      if (smem[i] !== fmem[i]) begin
        check(0, "R1 static contents", int'(smem[i]), int'(fmem[i]));
        break;
      end
    $display("copy %s checked", tag);
  endtask

  task automatic sw_copy(input int sel, input int seed, input bit poke_mid);
    int waited;
    int p;
    p = period_of(sel);
    @(posedge clk); #1;
    div_sel    = SEL_W'(sel);
    exp_period = p;
    load_and_expect(seed);
    xfer_req_set = 1'b1;
    @(posedge clk); #1;
    xfer_req_set = 1'b0;
    @(negedge clk);
    check(xfer_req == 1'b1, "R3 request set", int'(xfer_req), 1);
    check(xfer_done == 1'b0, "R3 done cleared", int'(xfer_done), 0);
    check(cal_state == 2'b00, "R3 state uncalibrated", int'(cal_state), 0);
    if (poke_mid) begin
      while (wr_count < WORDS / 2) @(negedge clk);
      @(posedge clk); #1;
      xfer_req_set = 1'b1;   // R4: ignored while running
      @(posedge clk); #1;
      xfer_req_set = 1'b0;
    end
    wait_done(waited);
    waited += 1;             // cycle from acceptance to first negedge above
    if (!poke_mid)
      check(waited >= (WORDS - 1) * p + 2 && waited <= WORDS * p + 2,
            "R7 copy duration", waited, WORDS * p + 2);
    finish_checks($sformatf("sel=%0d", sel));
    // R9: nothing more while idle
    for (int k = 0; k < 2 * p + 4; k++) @(negedge clk);
    check(wr_count == WORDS && xfer_done == 1'b1, "R9 quiet after done", wr_count, WORDS);
  endtask

  initial begin
    int waited;
    load_and_expect(3);
    exp_period = period_of(0);
    repeat (3) @(posedge clk);
    #1;
    check(xfer_done == 1'b0 && cal_state == 2'b00, "R8 reset state",
          int'({xfer_done, cal_state}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(xfer_req == 1'b1, "R1 request after reset", int'(xfer_req), 1);
    check(smem_wr_en == 1'b0 && xfer_done == 1'b0, "R8 first cycle", int'(smem_wr_en), 0);
    wait_done(waited);
    check(waited <= WORDS * 16 + 2, "R7 slowest setting duration", waited, WORDS * 16 + 2);
    finish_checks("after reset");

    sw_copy(2, 5, 0);
    sw_copy(4, 11, 0);
    sw_copy(7, 13, 0);       // clamps to period 1
    sw_copy(1, 9, 1);        // mid-copy request ignored
    sw_copy(0, 6, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule